// File: doc/BRIEF.md
# Cascadable Dual-Compare 8-Bit Timer

This block holds two 8-bit timer channels. Each channel has an up-counter, two compare registers named A and B, and a count clock. The count clock is one of six taps of a free-running prescaler or an external event input, and the block can also hold the counter stopped. Each channel can clear its counter on either compare or on an external reset level. Each compare event can set, clear or toggle the channel's output pin, which gives a PWM waveform of any duty cycle. Compare A, compare B and counter wrap each set a sticky flag, and each flag drives a maskable interrupt line.

The two channels can be chained into one 16-bit counter, with channel 0 as the high byte and channel 1 as the low byte. In a second chained mode, channel 1 counts the compare-A events of channel 0 instead of its own clock. Software reaches every setting through a flat register port. A write takes effect on the clock edge, and a read returns its data combinationally. Address bit 3 selects the channel and bits 2:0 select the register: 0 count, 1 compare A, 2 compare B, 3 control, 4 output actions, 5 flags, 6 interrupt enables, 7 chaining mode (channel 0 only).

Top module: `dual_timer8`

## Requirements
- R1: After reset every counter reads 0, every compare register reads 0xFF, outputs are low, and all flags, enables and interrupt lines are 0.
- R2: Control bits 2:0 pick the count clock: 0 stops the counter, k = 1..6 counts once every 4^k clocks of a free-running prescaler, and 7 uses the external clock input.
- R3: The external clock is synchronised through two flops. Control bit 5 chooses the counted edge (0 rising, 1 falling), and the other edge has no effect.
- R4: A compare event is a single-cycle pulse one clock after the counter first equals the compare register. It sets the matching flag (flag bit 0 for A, bit 1 for B).
- R5: Control bits 4:3 choose the clear source: 0 none, 1 on a count tick while equal to compare A, 2 the same for compare B, 3 while the synchronised external reset is high. With any other code, the external reset has no effect.
- R6: Output-action register bits 1:0 (compare A) and 3:2 (compare B) take the codes 0 keep, 1 low, 2 high, 3 toggle. When both events occur in the same cycle, the compare-A action wins.
- R7: A count tick at 0xFF wraps the counter to 0x00 and sets flag bit 2.
- R8: Flags stay set until software writes 1 to them, and writing 0 leaves a flag unchanged. Each interrupt line is its flag ANDed with the matching enable bit.
- R9: Mode 1 chains the channels into a 16-bit counter. Channel 1 is the low byte on its own clock, and channel 0 is the high byte, advancing on the low-byte carry. Channel 0 compare events and clearing use the concatenation {A0,A1} or {B0,B1}, and the clear selection of channel 0 governs both bytes.
- R10: Mode 2 makes channel 1 advance once per compare-A event of channel 0.
- R11: Writing the count register loads the counter. The counter never changes without a tick, a load or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address: bit 3 channel, bits 2:0 register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| extClk | input | 2 | External count clock per channel |
| extRst | input | 2 | External counter clear per channel |
| tmrOut | output | 2 | Compare-driven output pin per channel |
| irqCmA | output | 2 | Compare-A interrupt per channel |
| irqCmB | output | 2 | Compare-B interrupt per channel |
| irqOvf | output | 2 | Overflow interrupt per channel |

## Verification
A wrong counter value shows up on the count register at the next read. It also shows up within two clocks of the next expected match, because the output pin and flags then change at the wrong tick count. A wrong compare-edge state either leaves a flag unset or fires an extra event, and the output pin shows that one event later as a level or toggle error. A faulty carry or clear route in the chained modes leaves one byte out of step with the other after a single low-byte wrap or a single compare event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 8;
  localparam int NCH    = 2;
  localparam int FLG_W  = 3;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = ADDR_W - 1;

  localparam logic [IDX_W-1:0] REG_CNT  = 3'd0;
  localparam logic [IDX_W-1:0] REG_CMPA = 3'd1;
  localparam logic [IDX_W-1:0] REG_CMPB = 3'd2;
  localparam logic [IDX_W-1:0] REG_CTRL = 3'd3;
  localparam logic [IDX_W-1:0] REG_OUTC = 3'd4;
  localparam logic [IDX_W-1:0] REG_FLG  = 3'd5;
  localparam logic [IDX_W-1:0] REG_IEN  = 3'd6;
  localparam logic [IDX_W-1:0] REG_MODE = 3'd7;

  typedef enum logic [1:0] {CLR_NONE = 2'd0, CLR_CMA = 2'd1, CLR_CMB = 2'd2, CLR_EXT = 2'd3} clr_sel_e;
  typedef enum logic [1:0] {ACT_KEEP = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_TOGGLE = 2'd3} out_act_e;
  typedef enum logic [1:0] {CAS_OFF = 2'd0, CAS_WIDE = 2'd1, CAS_EVCNT = 2'd2, CAS_RSVD = 2'd3} cas_mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] cmpA;
    logic [CNT_W-1:0] cmpB;
    clr_sel_e         clrSel;
    out_act_e         actA;
    out_act_e         actB;
    logic [FLG_W-1:0] irqEn;
  } ch_cfg_t;

  typedef struct packed {
    logic             tick;
    logic             extClr;
    logic             cntWr;
    logic [CNT_W-1:0] cntData;
    logic [FLG_W-1:0] flagClr;
  } ch_strb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int TAP_CNT  = 6,
  parameter int TAP_STEP = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CNT_W-1:0]            wrData,
  output logic [CNT_W-1:0]            rdData,
  input  logic [NCH-1:0]              extClk,
  input  logic [NCH-1:0]              extRst,
  input  logic [NCH-1:0][CNT_W-1:0]   cntIn,
  input  logic [NCH-1:0][FLG_W-1:0]   flagsIn,
  output ch_cfg_t [NCH-1:0]           cfg,
  output ch_strb_t [NCH-1:0]          strb,
  output cas_mode_e                   mode
);
  localparam int PRE_W = TAP_CNT * TAP_STEP;
  localparam int SEL_N = 1 << SEL_W;
  localparam logic [SEL_W-1:0] EXT_SEL = SEL_W'(SEL_N - 1);

  logic [PRE_W-1:0] pre;
  logic [SEL_N-1:0] tapVec;
  logic             chSel;
  logic [IDX_W-1:0] regIdx;

  logic [CNT_W-1:0] cmpAR   [NCH];
  logic [CNT_W-1:0] cmpBR   [NCH];
  logic [SEL_W-1:0] clkSelR [NCH];
  clr_sel_e         clrSelR [NCH];
  logic             fallR   [NCH];
  out_act_e         actAR   [NCH];
  out_act_e         actBR   [NCH];
  logic [FLG_W-1:0] ienR    [NCH];
  cas_mode_e        modeR;

  assign chSel  = addr[ADDR_W-1];
  assign regIdx = addr[IDX_W-1:0];
  assign mode   = modeR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre   <= '0;
      modeR <= CAS_OFF;
      for (int c = 0; c < NCH; c++) begin
        cmpAR[c]   <= '1;
        cmpBR[c]   <= '1;
        clkSelR[c] <= '0;
        clrSelR[c] <= CLR_NONE;
        fallR[c]   <= 1'b0;
        actAR[c]   <= ACT_KEEP;
        actBR[c]   <= ACT_KEEP;
        ienR[c]    <= '0;
      end
    end else begin
      pre <= pre + 1'b1;
      if (wrEn) begin
        case (regIdx)
          REG_CMPA: cmpAR[chSel] <= wrData;
          REG_CMPB: cmpBR[chSel] <= wrData;
          REG_CTRL: begin
            clkSelR[chSel] <= wrData[SEL_W-1:0];
            clrSelR[chSel] <= clr_sel_e'(wrData[SEL_W+1:SEL_W]);
            fallR[chSel]   <= wrData[SEL_W+2];
          end
          REG_OUTC: begin
            actAR[chSel] <= out_act_e'(wrData[1:0]);
            actBR[chSel] <= out_act_e'(wrData[3:2]);
          end
          REG_IEN:  ienR[chSel] <= wrData[FLG_W-1:0];
          REG_MODE: if (!chSel) modeR <= cas_mode_e'(wrData[1:0]);
          default: ;
        endcase
      end
    end
  end

  // prescaler taps: tap k fires once every 2^(k*TAP_STEP) clocks
  for (genvar k = 0; k < SEL_N; k++) begin : g_tap
    if (k >= 1 && k <= TAP_CNT) begin : g_on
      assign tapVec[k] = &pre[k*TAP_STEP-1:0];
    end else begin : g_off
      assign tapVec[k] = 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [2:0] clkSync;
    logic [1:0] rstSync;
    logic       edgeHit;
    ch_strb_t   s;
    ch_cfg_t    c;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkSync <= '0;
        rstSync <= '0;
      end else begin
        clkSync <= {clkSync[1:0], extClk[g]};
        rstSync <= {rstSync[0], extRst[g]};
      end
    end

    assign edgeHit = fallR[g] ? (~clkSync[1] & clkSync[2]) : (clkSync[1] & ~clkSync[2]);

    always_comb begin
      s.tick    = (clkSelR[g] == EXT_SEL) ? edgeHit : tapVec[clkSelR[g]];
      s.extClr  = rstSync[1] && (clrSelR[g] == CLR_EXT);
      s.cntWr   = wrEn && (regIdx == REG_CNT) && (chSel == 1'(g));
      s.cntData = wrData;
      s.flagClr = (wrEn && (regIdx == REG_FLG) && (chSel == 1'(g))) ? wrData[FLG_W-1:0] : '0;
      c.cmpA    = cmpAR[g];
      c.cmpB    = cmpBR[g];
      c.clrSel  = clrSelR[g];
      c.actA    = actAR[g];
      c.actB    = actBR[g];
      c.irqEn   = ienR[g];
    end

    assign strb[g] = s;
    assign cfg[g]  = c;
  end

  always_comb begin
    rdData = '0;
    case (regIdx)
      REG_CNT:  rdData = cntIn[chSel];
      REG_CMPA: rdData = cmpAR[chSel];
      REG_CMPB: rdData = cmpBR[chSel];
      REG_CTRL: rdData = CNT_W'({fallR[chSel], clrSelR[chSel], clkSelR[chSel]});
      REG_OUTC: rdData = CNT_W'({actBR[chSel], actAR[chSel]});
      REG_FLG:  rdData = CNT_W'(flagsIn[chSel]);
      REG_IEN:  rdData = CNT_W'(ienR[chSel]);
      REG_MODE: rdData = chSel ? '0 : CNT_W'(modeR);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ch_cfg_t [NCH-1:0]           cfg,
  input  ch_strb_t [NCH-1:0]          strb,
  input  cas_mode_e                   mode,
  output logic [NCH-1:0][CNT_W-1:0]   cnt,
  output logic [NCH-1:0][FLG_W-1:0]   flags,
  output logic [NCH-1:0]              tmrOut,
  output logic [NCH-1:0]              evtA,
  output logic [NCH-1:0]              evtB,
  output logic [NCH-1:0]              irqA,
  output logic [NCH-1:0]              irqB,
  output logic [NCH-1:0]              irqO
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic     wide, evCnt;
  logic     eqWideA, eqWideB;
  logic     [NCH-1:0] eq8A, eq8B, tickEff, clrTick, extHit, eqClrA, eqClrB, eqEvtA, eqEvtB;
  clr_sel_e clrSrc [NCH];

  assign wide  = (mode == CAS_WIDE);
  assign evCnt = (mode == CAS_EVCNT);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      eq8A[i] = (cnt[i] == cfg[i].cmpA);
      eq8B[i] = (cnt[i] == cfg[i].cmpB);
    end
    eqWideA = &eq8A;
    eqWideB = &eq8B;
    // low byte / event-counting channel
    tickEff[1] = evCnt ? evtA[0] : strb[1].tick;
    clrTick[1] = tickEff[1];
    clrSrc[1]  = wide ? cfg[0].clrSel : cfg[1].clrSel;
    extHit[1]  = wide ? strb[0].extClr : strb[1].extClr;
    eqClrA[1]  = wide ? eqWideA : eq8A[1];
    eqClrB[1]  = wide ? eqWideB : eq8B[1];
    eqEvtA[1]  = eq8A[1];
    eqEvtB[1]  = eq8B[1];
    // high byte / first channel
    tickEff[0] = wide ? (strb[1].tick && cnt[1] == TOP) : strb[0].tick;
    clrTick[0] = wide ? strb[1].tick : strb[0].tick;
    clrSrc[0]  = cfg[0].clrSel;
    extHit[0]  = strb[0].extClr;
    eqClrA[0]  = wide ? eqWideA : eq8A[0];
    eqClrB[0]  = wide ? eqWideB : eq8B[0];
    eqEvtA[0]  = eqClrA[0];
    eqEvtB[0]  = eqClrB[0];
  end

  function automatic logic applyAct(input out_act_e act, input logic cur);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNT_W-1:0] cntQ;
    logic [FLG_W-1:0] flagQ;
    logic eqAQ, eqBQ, evtAQ, evtBQ, ovfQ, outQ;
    logic cmpHit, wrapNow;

    assign cmpHit  = clrTick[g] && (((clrSrc[g] == CLR_CMA) && eqClrA[g]) ||
                                    ((clrSrc[g] == CLR_CMB) && eqClrB[g]));
    assign wrapNow = tickEff[g] && (cntQ == TOP) && !cmpHit && !extHit[g] && !strb[g].cntWr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ  <= '0;
        flagQ <= '0;
        eqAQ  <= 1'b0;
        eqBQ  <= 1'b0;
        evtAQ <= 1'b0;
        evtBQ <= 1'b0;
        ovfQ  <= 1'b0;
        outQ  <= 1'b0;
      end else begin
        if (strb[g].cntWr)   cntQ <= strb[g].cntData;
        else if (extHit[g])  cntQ <= '0;
        else if (cmpHit)     cntQ <= '0;
        else if (tickEff[g]) cntQ <= cntQ + 1'b1;
        eqAQ  <= eqEvtA[g];
        eqBQ  <= eqEvtB[g];
        evtAQ <= eqEvtA[g] && !eqAQ;
        evtBQ <= eqEvtB[g] && !eqBQ;
        ovfQ  <= wrapNow;
        flagQ <= (flagQ & ~strb[g].flagClr) | {ovfQ, evtBQ, evtAQ};
        if (evtAQ)      outQ <= applyAct(cfg[g].actA, outQ);
        else if (evtBQ) outQ <= applyAct(cfg[g].actB, outQ);
      end
    end

    assign cnt[g]    = cntQ;
    assign flags[g]  = flagQ;
    assign tmrOut[g] = outQ;
    assign evtA[g]   = evtAQ;
    assign evtB[g]   = evtBQ;
    assign irqA[g]   = flagQ[0] & cfg[g].irqEn[0];
    assign irqB[g]   = flagQ[1] & cfg[g].irqEn[1];
    assign irqO[g]   = flagQ[2] & cfg[g].irqEn[2];
  end
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
  import tmr_pkg::*;
#(
  parameter int TAP_CNT  = 6,
  parameter int TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [1:0] extClk,
  input  logic [1:0] extRst,
  output logic [1:0] tmrOut,
  output logic [1:0] irqCmA,
  output logic [1:0] irqCmB,
  output logic [1:0] irqOvf
);
  ch_cfg_t  [NCH-1:0]            cfgV;
  ch_strb_t [NCH-1:0]            strbV;
  cas_mode_e                     casMode;
  logic     [NCH-1:0][CNT_W-1:0] cntV;
  logic     [NCH-1:0][FLG_W-1:0] flagsV;
  logic     [NCH-1:0]            evtAV, evtBV;

  tmr_ctrl #(.TAP_CNT(TAP_CNT), .TAP_STEP(TAP_STEP)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .extClk(extClk), .extRst(extRst), .cntIn(cntV), .flagsIn(flagsV),
    .cfg(cfgV), .strb(strbV), .mode(casMode)
  );

  tmr_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cfg(cfgV), .strb(strbV), .mode(casMode),
    .cnt(cntV), .flags(flagsV), .tmrOut(tmrOut), .evtA(evtAV), .evtB(evtBV),
    .irqA(irqCmA), .irqB(irqCmB), .irqO(irqOvf)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input cas_mode_e  mode,
  input out_act_e   actA0,
  input logic       tick0,
  input logic       cntWr0,
  input logic       extClr0,
  input logic [7:0] cnt0,
  input logic [2:0] flags0,
  input logic       out0,
  input logic       evtA0,
  input logic       evtB0
);
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == CAS_OFF && !tick0 && !cntWr0 && !extClr0) |=> $stable(cnt0));

  // R5
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extClr0 && !cntWr0) |=> (cnt0 == 8'd0));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtA0 |=> flags0[0]);

  // R4
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtA0 |=> !evtA0);

  // R6
  prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtA0 && actA0 == ACT_HIGH) |=> out0);

  // R6
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!evtA0 && !evtB0) |=> $stable(out0));
endmodule

bind dual_timer8 tmr_chk u_chk (
  .clk(clk), .rstN(rstN), .mode(casMode), .actA0(cfgV[0].actA),
  .tick0(strbV[0].tick), .cntWr0(strbV[0].cntWr), .extClr0(strbV[0].extClr),
  .cnt0(cntV[0]), .flags0(flagsV[0]), .out0(tmrOut[0]),
  .evtA0(evtAV[0]), .evtB0(evtBV[0])
);

// File: tb/dual_timer8_bench.sv
`timescale 1ns/1ps
module dual_timer8_bench;
  logic       clk = 1'b0;
  logic       rstN, wrEn;
  logic [3:0] addr;
  logic [7:0] wrData, rdData;
  logic [1:0] extClk, extRst, tmrOut, irqCmA, irqCmB, irqOvf;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_timer8 u_dual_timer8 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .extClk(extClk), .extRst(extRst), .tmrOut(tmrOut),
    .irqCmA(irqCmA), .irqCmB(irqCmB), .irqOvf(irqOvf)
  );

  typedef struct packed {
    logic [7:0] start, cmpA, cmpB;
    logic [1:0] clr, actA, actB;
    logic [7:0] n, expCnt;
    logic       expOut;
    logic [2:0] expFlg;
  } vec_t;

  // channel 0, external rising-edge clock; output carries over between rows
  localparam vec_t VECS [5] = '{
    '{8'h00, 8'h05, 8'h02, 2'd1, 2'd1, 2'd2, 8'd4,  8'd4, 1'b1, 3'd2},
    '{8'h00, 8'h05, 8'h02, 2'd1, 2'd1, 2'd2, 8'd7,  8'd1, 1'b0, 3'd3},
    '{8'h00, 8'h03, 8'h03, 2'd0, 2'd2, 2'd1, 8'd3,  8'd3, 1'b1, 3'd3},
    '{8'h00, 8'h09, 8'h04, 2'd2, 2'd0, 2'd3, 8'd10, 8'd0, 1'b1, 3'd2},
    '{8'hFE, 8'h10, 8'h20, 2'd0, 2'd0, 2'd0, 8'd3,  8'd1, 1'b1, 3'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int act, input int lo, input int hi);
    nChk++;
    if (act < lo || act > hi) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdData);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    extClk[ch] = 1'b1;
    idle(3);
    extClk[ch] = 1'b0;
    idle(3);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    int v, a;
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; extClk = '0; extRst = '0;
    idle(4);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, v); chk("R1 count0 reset", v, 0);
    rd(4'h1, v); chk("R1 cmpA0 reset", v, 255);
    rd(4'hA, v); chk("R1 cmpB1 reset", v, 255);
    rd(4'h5, v); chk("R1 flags0 reset", v, 0);
    chk("R1 outputs reset", int'(tmrOut), 0);
    chk("R1 irq reset", int'({irqCmA, irqCmB, irqOvf}), 0);

    // R4 R5 R6 R7: table walk
    foreach (VECS[i]) begin
      wr(4'h0, VECS[i].start);
      wr(4'h1, VECS[i].cmpA);
      wr(4'h2, VECS[i].cmpB);
      wr(4'h3, {3'b000, VECS[i].clr, 3'b111});
      wr(4'h4, {4'b0000, VECS[i].actB, VECS[i].actA});
      idle(4);
      wr(4'h5, 8'h07);
      for (int p = 0; p < int'(VECS[i].n); p++) pulse(0);
      idle(4);
      rd(4'h0, v); chk($sformatf("R5 R7 vec%0d count", i), v, int'(VECS[i].expCnt));
      rd(4'h5, v); chk($sformatf("R4 R7 vec%0d flags", i), v, int'(VECS[i].expFlg));
      chk($sformatf("R6 vec%0d output", i), int'(tmrOut[0]), int'(VECS[i].expOut));
    end

    // R8 masking and write-one-to-clear (overflow flag is set from last row)
    chk("R8 masked ovf irq", int'(irqOvf[0]), 0);
    wr(4'h6, 8'h04);
    chk("R8 enabled ovf irq", int'(irqOvf[0]), 1);
    wr(4'h5, 8'h01);
    chk("R8 other-bit clear keeps ovf", int'(irqOvf[0]), 1);
    wr(4'h5, 8'h04);
    chk("R8 ovf cleared", int'(irqOvf[0]), 0);

    // R3 falling edge select
    wr(4'h0, 8'h00);
    wr(4'h3, 8'h27);
    @(negedge clk); extClk[0] = 1'b1;
    idle(6);
    rd(4'h0, v); chk("R3 rising ignored in falling mode", v, 0);
    extClk[0] = 1'b0;
    idle(6);
    rd(4'h0, v); chk("R3 falling edge counted", v, 1);

    // R5 external reset clear, R11 load
    wr(4'h3, 8'h18);
    wr(4'h0, 8'h40);
    @(negedge clk); extRst[0] = 1'b1;
    idle(4);
    rd(4'h0, v); chk("R5 external reset clears", v, 0);
    extRst[0] = 1'b0;
    idle(4);
    wr(4'h0, 8'h22);
    rd(4'h0, v); chk("R11 count load", v, 34);
    wr(4'h3, 8'h00);
    @(negedge clk); extRst[0] = 1'b1;
    idle(4);
    rd(4'h0, v); chk("R5 external reset ignored when not selected", v, 34);
    extRst[0] = 1'b0;

    // R2 prescaler taps and stop
    wr(4'hB, 8'h01);
    wr(4'h8, 8'h00);
    idle(63);
    rd(4'h8, v); chkRange("R2 tap1 divide by 4", v, 15, 17);
    wr(4'hB, 8'h02);
    wr(4'h8, 8'h00);
    idle(63);
    rd(4'h8, v); chkRange("R2 tap2 divide by 16", v, 3, 5);
    wr(4'hB, 8'h00);
    rd(4'h8, a);
    idle(20);
    rd(4'h8, v); chk("R2 stopped holds", v, a);

    // R9 16-bit chaining: carry
    wr(4'hB, 8'h07);
    wr(4'h3, 8'h00);
    wr(4'h7, 8'h01);
    wr(4'h8, 8'hFF);
    wr(4'h0, 8'h00);
    pulse(1);
    idle(2);
    rd(4'h8, v); chk("R9 low byte wraps", v, 0);
    rd(4'h0, v); chk("R9 high byte takes carry", v, 1);
    // R9 16-bit compare clear governed by channel 0
    wr(4'h1, 8'h01);
    wr(4'h9, 8'h02);
    wr(4'h3, 8'h08);
    idle(4);
    wr(4'h5, 8'h07);
    pulse(1); pulse(1); pulse(1);
    idle(4);
    rd(4'h8, v); chk("R9 low byte cleared on 16-bit match", v, 0);
    rd(4'h0, v); chk("R9 high byte cleared on 16-bit match", v, 0);
    rd(4'h5, v); chk("R9 16-bit compare-A flag", v & 1, 1);

    // R10 compare-event counting
    wr(4'h7, 8'h02);
    wr(4'hB, 8'h00);
    wr(4'h8, 8'h00);
    wr(4'h0, 8'h00);
    wr(4'h1, 8'h02);
    wr(4'h3, 8'h0F);
    for (int p = 0; p < 6; p++) pulse(0);
    idle(4);
    rd(4'h8, v); chk("R10 channel1 counts channel0 matches", v, 2);
    rd(4'h0, v); chk("R10 channel0 cleared on match", v, 0);

    finishRun();
  end
endmodule